// File: doc/BRIEF.md
# One-Time-Programmable Byte Burn Sequencer

This controller writes a run of consecutive byte locations in a memory whose cells can only be driven from 0 to 1. For each location it places the address and the byte on the memory port and fires a fixed-length program pulse. It then raises the verify strobe and compares the byte read back with the intended one. It keeps going until the read matches or the attempt budget is spent. A matching location gets one extra pulse. The length of that pulse is a fixed multiple of the pulse time already spent on that same location. Only then does the sequencer step to the next address.

A host presents a first address, a last address, a data-source select and a fill byte, and pulses `start`. The data source is either the fill byte for every location or a byte that the host supplies on `src_byte` as a function of the current `mem_addr`. All durations are counted in clock cycles and derived from the `CLK_HZ` parameter. One basic pulse is one millisecond, and one setup or hold unit is one microsecond rounded up. The run ends with `done` held high, or with `fail` held high and the offending address on `fail_addr`.

Top module: `otp_prog_seq`

## Requirements
- R1: While and after reset, until the first accepted start, `busy`, `done`, `fail`, `mem_pgm` and `mem_vfy` are 0 and `fail_addr` is 0.
- R2: `start` is accepted only when `busy` is 0. It latches first address, last address, source select and fill byte. The next cycle is a single load cycle with `busy`=1, both strobes low and `mem_addr` equal to the first address. A `start` while `busy` is 1 has no effect on any output.
- R3: With `use_ext`=0 every location is written with the latched fill byte. With `use_ext`=1 each location is written with the value of `src_byte` seen during that location's load cycle.
- R4: Each attempt is US cycles with both strobes low (US = ceil(CLK_HZ/1e6)), then `mem_pgm` high for P = CLK_HZ/1000 cycles, then US cycles low, then `mem_vfy` high for 2·US cycles. `mem_addr` and `mem_wdata` stay constant across the attempt, and the two strobes are never high together.
- R5: `mem_rdata` is compared in the last verify cycle. On a mismatch with fewer than MAX_TRIES attempts made, the next cycle begins a new attempt.
- R6: On a match after a attempts, the sequencer gives US low cycles, then `mem_pgm` high for OVR_MULT·a·P cycles, then US low cycles.
- R7: The pulse total behind the extra pulse restarts at zero for each address, so each address's extra pulse depends only on its own attempt count.
- R8: After the extra pulse's trailing US cycles, if the current address is at or above the last address the next cycle has `done`=1 and `busy`=0. Otherwise the next cycle is the load cycle of the address plus one.
- R9: A mismatch on attempt MAX_TRIES sets `fail`=1 and `busy`=0 on the next cycle, with `fail_addr` equal to the failing address. No further strobes follow, and later addresses are never pulsed.
- R10: `done` and `fail` are never both 1. Each stays high until the next accepted start, and in the load cycle after that start both are 0.
- R11: A target byte that would need any bit of the stored byte to go from 1 to 0 never verifies, so that location ends in `fail`.
- R12: If the last address is below the first address, only the first address is programmed and then `done` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle, done or failed |
| first_addr | input | ADDR_W | First location of the run |
| last_addr | input | ADDR_W | Last location of the run |
| use_ext | input | 1 | 1: bytes from src_byte, 0: fill byte |
| fill_byte | input | DATA_W | Byte written everywhere when use_ext is 0 |
| src_byte | input | DATA_W | Host byte for the location on mem_addr |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_pgm | output | 1 | Program strobe |
| mem_vfy | output | 1 | Verify strobe |
| mem_rdata | input | DATA_W | Data read during verify |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, all locations verified |
| fail | output | 1 | Run stopped on a location that did not verify |
| fail_addr | output | ADDR_W | Failing location while fail is 1, else 0 |

## Verification
A behavioural memory model lets each cell require a chosen number of pulses before its bits stick. The bench uses it to predict every cycle of the strobe, address, data and status outputs from the requirements alone. A run where every cell takes on the first pulse separates the basic attempt timing and the address stepping. A run where cells need one, two, three and five pulses shows whether the retry loop and the per-address extra-pulse length are right. Other runs cover a cell needing six pulses, a cell that needs a 1-to-0 change, a reversed address range, and a start raised mid-run. Those runs tell apart the fail path, the range clamp and the ignored start.

// File: rtl/otp_prog_seq.sv
module otp_prog_seq #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int CLK_HZ    = 50_000_000,
  parameter int MAX_TRIES = 5,
  parameter int OVR_MULT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              use_ext,
  input  logic [DATA_W-1:0] fill_byte,
  input  logic [DATA_W-1:0] src_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_pgm,
  output logic              mem_vfy,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int P_CYC   = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int US_CYC  = (CLK_HZ + 999_999) / 1_000_000;
  localparam int VFY_CYC = 2 * US_CYC;
  localparam int OVR_MAX = OVR_MULT * MAX_TRIES * P_CYC;
  localparam int CNT_W   = $clog2(OVR_MAX + 1) + 1;
  localparam int TRY_W   = $clog2(MAX_TRIES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SETUP, S_PULSE, S_HOLD, S_VFY, S_DONE, S_FAIL
  } state_t;

  state_t            st;
  logic [ADDR_W-1:0] addr, last_q;
  logic              ext_q, extra;
  logic [DATA_W-1:0] fill_q, wdata;
  logic [CNT_W-1:0]  cnt, acc;
  logic [TRY_W-1:0]  tries;

  wire cnt_end = (cnt == '0);
  wire match   = (mem_rdata == wdata);

  assign mem_addr  = addr;
  assign mem_wdata = wdata;
  assign mem_pgm   = (st == S_PULSE);
  assign mem_vfy   = (st == S_VFY);
  assign done      = (st == S_DONE);
  assign fail      = (st == S_FAIL);
  assign busy      = !(st == S_IDLE || done || fail);
  assign fail_addr = fail ? addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      last_q <= '0;
      ext_q  <= 1'b0;
      fill_q <= '0;
      wdata  <= '0;
      cnt    <= '0;
      acc    <= '0;
      tries  <= '0;
      extra  <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL: if (start) begin
          addr   <= first_addr;
          last_q <= last_addr;
          ext_q  <= use_ext;
          fill_q <= fill_byte;
          st     <= S_LOAD;
        end
        S_LOAD: begin
          wdata <= ext_q ? src_byte : fill_q;
          acc   <= '0;
          tries <= '0;
          extra <= 1'b0;
          cnt   <= CNT_W'(US_CYC - 1);
          st    <= S_SETUP;
        end
        S_SETUP: if (cnt_end) begin
          cnt <= extra ? CNT_W'(OVR_MULT * int'(acc) - 1) : CNT_W'(P_CYC - 1);
          st  <= S_PULSE;
        end else cnt <= cnt - CNT_W'(1);
        S_PULSE: if (cnt_end) begin
          if (!extra) begin
            acc   <= acc + CNT_W'(P_CYC);
            tries <= tries + TRY_W'(1);
          end
          cnt <= CNT_W'(US_CYC - 1);
          st  <= S_HOLD;
        end else cnt <= cnt - CNT_W'(1);
        S_HOLD: if (cnt_end) begin
          if (!extra) begin
            cnt <= CNT_W'(VFY_CYC - 1);
            st  <= S_VFY;
          end else if (addr >= last_q) st <= S_DONE;
          else begin
            addr <= addr + ADDR_W'(1);
            st   <= S_LOAD;
          end
        end else cnt <= cnt - CNT_W'(1);
        S_VFY: if (cnt_end) begin
          if (match) begin
            extra <= 1'b1;
            cnt   <= CNT_W'(US_CYC - 1);
            st    <= S_SETUP;
          end else if (int'(tries) >= MAX_TRIES) st <= S_FAIL;
          else begin
            cnt <= CNT_W'(US_CYC - 1);
            st  <= S_SETUP;
          end
        end else cnt <= cnt - CNT_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_pgm && mem_vfy)); // R4
  AST_PORT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_pgm || mem_vfy) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R4
  AST_TRIES_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tries) <= MAX_TRIES); // R5
  AST_FAIL_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> (int'(tries) == MAX_TRIES)); // R9
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R10
  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (mem_addr >= last_q)); // R8
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_pgm || mem_vfy)); // R9

endmodule

// File: tb/test_otp_prog_seq.sv
`timescale 1ns/1ps
module test_otp_prog_seq;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int HZ = 40_000;
  localparam int MT = 5;
  localparam int XM = 2;
  localparam int P  = HZ / 1000;
  localparam int US = (HZ + 999_999) / 1_000_000;
  localparam int NLOC = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, use_ext, mem_pgm, mem_vfy, busy, done, fail;
  logic [AW-1:0] first_addr, last_addr, mem_addr, fail_addr;
  logic [DW-1:0] fill_byte, src_byte, mem_wdata, mem_rdata;

  otp_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_HZ(HZ), .MAX_TRIES(MT), .OVR_MULT(XM)) i_otp_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr), .last_addr(last_addr),
    .use_ext(use_ext), .fill_byte(fill_byte), .src_byte(src_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_pgm(mem_pgm), .mem_vfy(mem_vfy), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr));

  logic [DW-1:0] mem [NLOC];
  int need [NLOC];
  int pcnt [NLOC];
  logic pgm_d = 1'b0;
  int checks = 0, failures = 0;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 29 + 3);
  endfunction

  assign mem_rdata = mem[mem_addr];
  assign src_byte  = pat(int'(mem_addr));

  always @(posedge clk) begin
    pgm_d <= mem_pgm;
    if (mem_pgm && !pgm_d) begin
      pcnt[mem_addr] <= pcnt[mem_addr] + 1;
      if (pcnt[mem_addr] + 1 >= need[mem_addr]) mem[mem_addr] <= mem[mem_addr] | mem_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int q_a[$], q_w[$], q_s[$];
  int exp_fail, exp_faddr;
  int ok_a[$], ok_d[$];

  task automatic push(input int a, input int w, input int s, input int n);
    for (int i = 0; i < n; i++) begin q_a.push_back(a); q_w.push_back(w); q_s.push_back(s); end
  endtask

  // s = {pgm, vfy, busy, done, fail}
  task automatic build(input int first, input int last, input bit ext, input int fill);
    int a;
    a = first;
    exp_fail = 0; exp_faddr = 0;
    ok_a.delete(); ok_d.delete();
    forever begin
      int d, att;
      bit ok;
      d = ext ? int'(pat(a)) : fill;
      push(a, -1, 5'b00100, 1);
      ok = 0; att = 0;
      for (int t = 1; t <= MT; t++) begin
        int v;
        push(a, d, 5'b00100, US);
        push(a, d, 5'b10100, P);
        push(a, d, 5'b00100, US);
        push(a, d, 5'b01100, 2 * US);
        v = int'(mem[a]) | ((t >= need[a]) ? d : 0);
        if (v == d) begin ok = 1; att = t; break; end
      end
      if (!ok) begin
        push(a, -1, 5'b00001, 1);
        exp_fail = 1; exp_faddr = a;
        return;
      end
      ok_a.push_back(a); ok_d.push_back(d);
      push(a, d, 5'b00100, US);
      push(a, d, 5'b10100, XM * att * P);
      push(a, d, 5'b00100, US);
      if (a >= last) begin push(a, -1, 5'b00010, 1); return; end
      a++;
    end
  endtask

  task automatic run(input int first, input int last, input bit ext, input int fill,
                     input int disturb, input string req);
    int n, bad, ga, gs, ea, es;
    build(first, last, ext, fill);
    @(negedge clk);
    first_addr = AW'(first); last_addr = AW'(last); use_ext = ext; fill_byte = DW'(fill);
    start = 1'b1;
    n = 0; bad = 0;
    while (q_a.size() > 0) begin
      int a, w, s;
      @(negedge clk);
      if (n == 0) start = 1'b0;
      a = q_a.pop_front(); w = q_w.pop_front(); s = q_s.pop_front();
      if (!bad && (int'({mem_pgm, mem_vfy, busy, done, fail}) != s || int'(mem_addr) != a ||
                   (w >= 0 && int'(mem_wdata) != w))) begin
        bad = 1; ga = int'(mem_addr); gs = int'({mem_pgm, mem_vfy, busy, done, fail});
        ea = a; es = s;
        $display("  cycle %0d: addr %0h/%0h wdata %0h/%0h", n, ga, ea, mem_wdata, w);
      end
      if (disturb > 0 && n == disturb) begin
        start = 1'b1; first_addr = AW'(50); last_addr = AW'(55); fill_byte = 8'hC3;
      end
      if (disturb > 0 && n == disturb + 1) start = 1'b0;
      n++;
    end
    check(!bad, {req, " timeline"}, bad ? gs : 0, bad ? es : 0);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NLOC; i++) begin mem[i] = '0; need[i] = 1; pcnt[i] = 0; end
    rst_n = 1'b0; start = 1'b0; use_ext = 1'b0; first_addr = '0; last_addr = '0; fill_byte = '0;
    repeat (3) @(negedge clk);
    check({busy, done, fail, mem_pgm, mem_vfy} == 5'b0 && fail_addr == '0, "R1 reset outputs",
          int'({busy, done, fail, mem_pgm, mem_vfy}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, fail, mem_pgm, mem_vfy} == 5'b0, "R1 after reset",
          int'({busy, done, fail, mem_pgm, mem_vfy}), 0);

    // R2 R4 R6 R8: one pulse per cell, fill source, start raised mid-run is ignored
    run(2, 4, 1'b0, 8'h5A, 10, "R2 R4 R6 R8");
    for (int i = 0; i < ok_a.size(); i++)
      check(mem[ok_a[i]] == DW'(ok_d[i]), "R3 fill byte stored", mem[ok_a[i]], ok_d[i]);
    check(done && !fail && !busy, "R8 done raised", int'({done, fail, busy}), 3'b100);
    check(pcnt[50] == 0, "R2 ignored start pulsed nothing", pcnt[50], 0);
    repeat (4) @(negedge clk);
    check(done && !fail, "R10 done held", int'({done, fail}), 2'b10);

    // R3 R5 R7: external bytes, cells needing 1, 3, 5, 2 pulses
    need[8] = 1; need[9] = 3; need[10] = 5; need[11] = 2;
    run(8, 11, 1'b1, 8'h00, 0, "R5 R7");
    for (int i = 0; i < ok_a.size(); i++)
      check(mem[ok_a[i]] == pat(ok_a[i]), "R3 external byte stored", mem[ok_a[i]], pat(ok_a[i]));
    check(ok_a.size() == 4 && done, "R5 all retried cells verified", ok_a.size(), 4);

    // R9: cell needing six pulses
    need[19] = 1; need[20] = 6; need[21] = 1;
    run(19, 21, 1'b0, 8'hA5, 0, "R9");
    check(fail && !done && !busy, "R9 fail raised", int'({fail, done, busy}), 3'b100);
    check(exp_fail == 1 && int'(fail_addr) == exp_faddr, "R9 fail_addr", fail_addr, 20);
    repeat (6) @(negedge clk);
    check(!mem_pgm && !mem_vfy && fail, "R9 quiet after fail", int'({mem_pgm, mem_vfy, fail}), 1);
    check(pcnt[21] == 0, "R9 later address untouched", pcnt[21], 0);

    // R10 R11: restart from fail, byte needing a 1-to-0 change
    mem[30] = 8'hF0;
    run(30, 30, 1'b0, 8'h0F, 0, "R10 R11");
    check(fail && int'(fail_addr) == 30, "R11 unreachable byte fails", fail_addr, 30);
    check(pcnt[30] == MT, "R11 attempt count", pcnt[30], MT);

    // R12: reversed range
    run(40, 35, 1'b0, 8'h3C, 0, "R12");
    check(done && mem[40] == 8'h3C, "R12 first address programmed", mem[40], 8'h3C);
    check(pcnt[41] == 0 && pcnt[39] == 0 && pcnt[35] == 0, "R12 no other address",
          pcnt[41] + pcnt[39] + pcnt[35], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule